// File: doc/BRIEF.md
# Three-Lane Serializer with Clock Lane

This block takes a 21-bit parallel word once per word period and splits it into three 7-bit groups. Each group drives its own serial lane, one bit per bit slot. A fourth lane carries a clock pattern at parallel rate, so that a receiver can find the word boundaries.

The block runs on a single fast clock. An external bit enable marks each bit slot, and a word strobe, qualified by the bit enable, marks the first slot of a word. A mode input picks the lane format for each word:

- **Raw format:** 7 slots per lane, no coding.
- **Balanced format:** 9 slots per lane. The 7 data bits may be inverted to keep the lane's ones/zeros count near even. Two complementary flag bits after the data tell the receiver whether the data was inverted.

In balanced format the clock lane alternates between 4 high slots and 5 high slots on successive words, which keeps the clock lane DC balanced too. The analog drivers and the clock multiplier that makes the bit clock lie outside this block.

Top module: `tri_lane_serializer`

## Requirements
- R1: Lane L (0..2) carries par_data bits 7L..7L+6. In raw format, slot k (0..6) of lane L is par_data bit 7L+k, so the lowest-numbered bit is sent first.
- R2: A word and its mode are captured on a bit_en cycle with word_sync high. The word is sent starting at the next such cycle, so the latency is exactly one word. Slot 0 is visible right after that capturing edge.
- R3: In raw format a word occupies 7 slots. The slot counter returns to slot 0 after slot 6.
- R4: In balanced format a word occupies 9 slots. Slots 0..6 hold the 7 data bits, each XORed with the inversion flag F. Slot 7 holds F and slot 8 holds the complement of F.
- R5: Each lane keeps a running sum, adding +1 for every one and -1 for every zero it has sent. For a balanced word with disparity d (ones minus zeros of the raw 7 bits), F=1 when the sum is >= 0 and d > 0, or when the sum is < 0 and d < 0. Otherwise F=0. The sum then moves by -d when F=1 and by +d when F=0. A raw word clears the sum to 0.
- R6: At every word boundary within a run of balanced words, the running sum observed on each data lane lies within -7..+7.
- R7: In raw format the clock lane is high in slots 0..3 and low in slots 4..6.
- R8: In balanced format the clock lane is high for the first H slots of the word and low for the rest. H alternates 4, 5, 4, 5, ..., starting with 4 on the first balanced word after reset or after a raw word. The running sum of the clock lane never leaves -5..+5.
- R9: A cycle with bit_en low changes no output and no state.
- R10: bal_sel is sampled together with the word it accompanies (1 = balanced, 0 = raw). It sets the format of that word only, so the mode can change from one word to the next.
- R11: After reset all data lanes are 0, the clock lane is 1, every running sum is 0 and the held word is all-zero raw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks a bit slot |
| word_sync | input | 1 | First slot of a word; only acts when bit_en is high |
| par_data | input | 21 | Parallel word, captured at word_sync |
| bal_sel | input | 1 | Format for the word captured with it: 1 balanced, 0 raw |
| lane_out | output | 3 | Serial data bits, one per lane |
| clk_lane | output | 1 | Clock-pattern lane |

## Verification
A corrupted running sum in one lane shows up as a wrong flag pair, and possibly wrongly inverted data, in slots 0..8 of that lane's next balanced word. It is therefore visible within one word. A slot counter that wraps at the wrong count, or a mode applied to the wrong word, bends the clock-lane pattern within the same word. The alternation flag shows a fault on the next balanced word, as a 4/5 mismatch. A missing hold on idle cycles appears on the next bit_en-low cycle, as an output that moves without a slot being consumed.

// File: rtl/serx_pkg.sv
// Shared definitions for the three-lane serializer.
// Assumes: a word format is one of two encodings selected per word.
package serx_pkg;

    // Per-word lane format
    typedef enum logic {
        FMT_RAW = 1'b0,
        FMT_BAL = 1'b1
    } lane_fmt_e;

    // Number of complementary flag slots appended to a balanced word
    localparam int unsigned FLAG_SLOTS = 2;

endpackage

// File: rtl/serx_lane_coder.sv
// One serial data lane: balance coder plus output shift register.
// On load, the lane encodes the held 7-bit group (raw, or balanced with
// inversion and a flag pair) and puts it into the shift register.
// Assumes: load and shift are never both high; both are qualified by the
// bit enable in the parent.
module serx_lane_coder
    import serx_pkg::*;
#(
    parameter int unsigned LANE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              bal,
    input  logic [LANE_W-1:0] word,
    output logic              ser_out
);
    localparam int unsigned SYM_W  = LANE_W + FLAG_SLOTS;
    localparam int unsigned ONES_W = $clog2(LANE_W + 1);
    localparam int unsigned SUM_W  = ONES_W + 2;

    logic [SYM_W-1:0]        sreg;
    logic signed [SUM_W-1:0] run_sum;
    logic [ONES_W-1:0]       ones;
    logic signed [SUM_W-1:0] disp;
    logic                    invert;
    logic [SYM_W-1:0]        symbol;

    // Count ones in the group and turn the count into a signed disparity
    always_comb begin
        ones = '0;
        for (int i = 0; i < LANE_W; i++) begin
            ones = ones + ONES_W'(word[i]);
        end
        disp = $signed({1'b0, ones, 1'b0}) - $signed(SUM_W'(LANE_W));
    end

    // Invert when the group would push the running sum further from zero
    always_comb begin
        if (run_sum >= 0) begin
            invert = (disp > 0);
        end else begin
            invert = (disp < 0);
        end
        if (bal) begin
            symbol = {~invert, invert, word ^ {LANE_W{invert}}};
        end else begin
            symbol = {{FLAG_SLOTS{1'b0}}, word};
        end
    end

    // Load a new symbol, or shift the current one out least-significant first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            run_sum <= '0;
        end else if (load) begin
            sreg    <= symbol;
            run_sum <= bal ? (invert ? run_sum - disp : run_sum + disp) : '0;
        end else if (shift) begin
            sreg    <= sreg >> 1;
        end
    end

    assign ser_out = sreg[0];

endmodule

// File: rtl/serx_slot_timer.sv
// Slot counter and clock-lane pattern generator.
// Counts bit slots within a word, wraps at the length of the active
// format, and drives the clock lane high for the first H slots. In
// balanced format H alternates short/long between words.
// Assumes: load restarts a word; shift advances one slot.
module serx_slot_timer
    import serx_pkg::*;
#(
    parameter int unsigned LANE_W = 7,
    parameter int unsigned CNT_W  = $clog2(LANE_W + FLAG_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             bal_next,
    output logic [CNT_W-1:0] slot,
    output logic             bal_act,
    output logic             clk_lane
);
    localparam int unsigned SYM_W    = LANE_W + FLAG_SLOTS;
    localparam int unsigned RAW_HI   = (LANE_W + 1) / 2;
    localparam int unsigned SHORT_HI = (SYM_W - 1) / 2;
    localparam int unsigned LONG_HI  = SYM_W - SHORT_HI;

    logic             alt;
    logic [CNT_W-1:0] last_slot;
    logic [CNT_W-1:0] high_len;

    // Last slot index and high length for the active format
    always_comb begin
        last_slot = bal_act ? CNT_W'(SYM_W - 1) : CNT_W'(LANE_W - 1);
        if (!bal_act) begin
            high_len = CNT_W'(RAW_HI);
        end else if (alt) begin
            high_len = CNT_W'(SHORT_HI);
        end else begin
            high_len = CNT_W'(LONG_HI);
        end
    end

    // Advance the slot counter and track format and high-length phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot    <= '0;
            bal_act <= 1'b0;
            alt     <= 1'b0;
        end else if (load) begin
            slot    <= '0;
            bal_act <= bal_next;
            alt     <= bal_next ? ~alt : 1'b0;
        end else if (shift) begin
            slot    <= (slot == last_slot) ? '0 : slot + 1'b1;
        end
    end

    assign clk_lane = (slot < high_len);

endmodule

// File: rtl/tri_lane_serializer.sv
// Top of the three-lane serializer.
// Holds the word and its format captured at a word strobe, then hands them
// to the lane coders and the slot timer at the following strobe.
// Assumes: word_sync arrives every 7 (raw) or 9 (balanced) bit slots,
// matching the format of the word in flight.
module tri_lane_serializer
    import serx_pkg::*;
#(
    parameter int unsigned LANES  = 3,
    parameter int unsigned LANE_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_en,
    input  logic                      word_sync,
    input  logic [LANES*LANE_W-1:0]   par_data,
    input  logic                      bal_sel,
    output logic [LANES-1:0]          lane_out,
    output logic                      clk_lane
);
    localparam int unsigned DATA_W = LANES * LANE_W;
    localparam int unsigned SYM_W  = LANE_W + FLAG_SLOTS;
    localparam int unsigned CNT_W  = $clog2(SYM_W);

    logic              load;
    logic              shift;
    logic [DATA_W-1:0] held_word;
    lane_fmt_e         held_fmt;
    logic              held_bal;
    logic [CNT_W-1:0]  slot;
    logic              bal_act;

    assign load     = bit_en & word_sync;
    assign shift    = bit_en & ~word_sync;
    assign held_bal = (held_fmt == FMT_BAL);

    // Capture the incoming word and its format for one word of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            held_fmt  <= FMT_RAW;
        end else if (load) begin
            held_word <= par_data;
            held_fmt  <= bal_sel ? FMT_BAL : FMT_RAW;
        end
    end

    // One coder per lane, each fed its own slice of the held word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        serx_lane_coder #(
            .LANE_W (LANE_W)
        ) u_coder (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .shift   (shift),
            .bal     (held_bal),
            .word    (held_word[g*LANE_W +: LANE_W]),
            .ser_out (lane_out[g])
        );
    end

    serx_slot_timer #(
        .LANE_W (LANE_W),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .bal_next (held_bal),
        .slot     (slot),
        .bal_act  (bal_act),
        .clk_lane (clk_lane)
    );

endmodule

// File: rtl/serx_checker.sv
// Property checker for the three-lane serializer, bound to the top.
// Tracks the clock-lane running sum and the previous slot's lane bits.
module serx_checker #(
    parameter int unsigned LANES  = 3,
    parameter int unsigned LANE_W = 7,
    parameter int unsigned CNT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             word_sync,
    input logic [LANES-1:0] lane_out,
    input logic             clk_lane,
    input logic [CNT_W-1:0] slot,
    input logic             bal_act
);
    localparam int unsigned SYM_W = LANE_W + 2;

    logic [LANES-1:0]  prev_lane;
    logic signed [4:0] ck_sum;

    // Remember last consumed lane bits and accumulate the clock-lane sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lane <= '0;
            ck_sum    <= '0;
        end else if (bit_en) begin
            prev_lane <= lane_out;
            if (bal_act) begin
                ck_sum <= clk_lane ? ck_sum + 5'sd1 : ck_sum - 5'sd1;
            end else begin
                ck_sum <= '0;
            end
        end
    end

    a_r2_strobe_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && word_sync) |=> (slot == '0));

    a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= (bal_act ? CNT_W'(SYM_W - 1) : CNT_W'(LANE_W - 1)));

    a_r4_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_act && slot == CNT_W'(SYM_W - 1)) |-> (lane_out == ~prev_lane));

    a_r7_raw_clk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!bal_act && bit_en && !word_sync && slot == CNT_W'(3)) |=> !clk_lane);

    a_r8_clk_dsv: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_sum <= 5'sd5) && (ck_sum >= -5'sd5));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(lane_out) && $stable(clk_lane) && $stable(slot)));

endmodule

bind tri_lane_serializer serx_checker #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .CNT_W  (CNT_W)
) u_serx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .word_sync (word_sync),
    .lane_out  (lane_out),
    .clk_lane  (clk_lane),
    .slot      (slot),
    .bal_act   (bal_act)
);

// File: tb/tri_lane_serializer_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random words, compared
// against a reference model built from the requirements.
module tri_lane_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_en;
    logic        word_sync;
    logic [20:0] par_data;
    logic        bal_sel;
    logic [2:0]  lane_out;
    logic        clk_lane;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [20:0] m_word;
    logic        m_bal;
    logic        m_alt;
    int          m_sum [3];
    int          obs_sum [3];

    always #10 clk = ~clk;

    tri_lane_serializer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .word_sync (word_sync),
        .par_data  (par_data),
        .bal_sel   (bal_sel),
        .lane_out  (lane_out),
        .clk_lane  (clk_lane)
    );

    // Expected 9-slot symbol for one lane group (R4, R5)
    function automatic logic [8:0] enc(input logic [6:0] w, input logic bal, inout int rs);
        int  c;
        int  d;
        logic inv;
        c = 0;
        for (int i = 0; i < 7; i++) c += w[i];
        d = 2 * c - 7;
        inv = (rs >= 0) ? (d > 0) : (d < 0);
        if (bal) begin
            rs = inv ? rs - d : rs + d;
            return {~inv, inv, w ^ {7{inv}}};
        end
        rs = 0;
        return {2'b00, w};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Send one word; check the previously held word as it shifts out
    task automatic send_word(input logic [20:0] data, input logic bal, input int gap_pct);
        logic [8:0] sym [3];
        logic       act;
        int         n;
        int         hi;
        act = m_bal;
        for (int l = 0; l < 3; l++) sym[l] = enc(m_word[7*l +: 7], act, m_sum[l]);
        n  = act ? 9 : 7;
        m_alt = act ? ~m_alt : 1'b0;
        hi = act ? (m_alt ? 4 : 5) : 4;
        m_word = data;
        m_bal  = bal;
        if (!act) for (int l = 0; l < 3; l++) obs_sum[l] = 0;
        for (int k = 0; k < n; k++) begin
            bit_en    = 1'b1;
            word_sync = (k == 0);
            if (k == 0) begin
                par_data = data;
                bal_sel  = bal;
            end else begin
                par_data = 21'($urandom);
                bal_sel  = 1'($urandom);
            end
            @(posedge clk);
            @(negedge clk);
            for (int l = 0; l < 3; l++) begin
                check(lane_out[l] == sym[l][k],
                      act ? "R4 R5 R2 R10 data slot" : "R1 R2 R3 R10 data slot",
                      lane_out[l], sym[l][k]);
                if (act) obs_sum[l] += lane_out[l] ? 1 : -1;
            end
            check(clk_lane == (k < hi), act ? "R8 clock lane" : "R7 R3 clock lane",
                  clk_lane, (k < hi));
            if (($urandom % 100) < gap_pct) begin
                bit_en    = 1'b0;
                word_sync = 1'($urandom);
                par_data  = 21'($urandom);
                @(posedge clk);
                @(negedge clk);
                for (int l = 0; l < 3; l++)
                    check(lane_out[l] == sym[l][k], "R9 idle hold", lane_out[l], sym[l][k]);
                check(clk_lane == (k < hi), "R9 idle hold clock", clk_lane, (k < hi));
            end
        end
        if (act) begin
            for (int l = 0; l < 3; l++)
                check(obs_sum[l] >= -7 && obs_sum[l] <= 7, "R6 boundary sum", obs_sum[l], 7);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd51423));
        rst_n = 1'b0; bit_en = 1'b0; word_sync = 1'b0; par_data = '0; bal_sel = 1'b0;
        m_word = '0; m_bal = 1'b0; m_alt = 1'b0;
        for (int l = 0; l < 3; l++) begin m_sum[l] = 0; obs_sum[l] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check(lane_out == 3'b000, "R11 reset lanes", lane_out, 0);
        check(clk_lane == 1'b1, "R11 reset clock lane", clk_lane, 1);

        // R1: walking one through every input bit in raw format
        for (int b = 0; b < 21; b++) send_word(21'(1) << b, 1'b0, 0);
        send_word(21'h0AAAAA, 1'b0, 0);
        // R5: all-ones balanced words force inversion, then all-zeros
        send_word(21'h1FFFFF, 1'b1, 0);
        send_word(21'h1FFFFF, 1'b1, 0);
        send_word(21'h000000, 1'b1, 0);
        send_word(21'h000000, 1'b1, 0);
        send_word(21'h0F0F0F, 1'b1, 30);
        // R10: mode changes word to word
        send_word(21'h155555, 1'b0, 0);
        send_word(21'h12345A, 1'b1, 0);
        send_word(21'h0ABCDE, 1'b0, 0);
        send_word(21'h1FFFFF, 1'b1, 0);
        // Random mix with idle gaps
        for (int i = 0; i < 300; i++)
            send_word(21'($urandom), ($urandom % 4) != 0, 25);
        send_word(21'h0, 1'b0, 0);
        send_word(21'h0, 1'b0, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule